// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the delivery state of a bank of interrupt sources and decides when each of them is offered to the presentation side of an interrupt system. Each source is fixed at build time as level-sensitive or message-type. A source holds a target server number, an 8-bit priority and an 8-bit saved priority. A level source tracks whether its line is asserted and whether it has already been sent. A message source tracks whether a delivery was bounced back and whether a pulse arrived while it was masked.

The presentation side drives commands into the block. A reject hands a delivery back to its source. An end-of-interrupt finishes the handling of a source. A resend asks every source to try again. Each command names a source by its global number, which is the local index plus a fixed base. Offers leave the block on a valid/ready channel, one per accepted handshake. When more than one source wants delivery, the lowest local index goes first. The priority value 0xFF masks a source.

Top module: `irq_src_ctrl`

## Requirements
- R1: No offer is ever presented for a source whose priority is 0xFF, and a level source asserted while masked makes no offer.
- R2: A rising input on an unmasked message source produces one offer carrying the source's server, global number BASE+index and priority, visible in the cycle after the rising edge is sampled.
- R3: A rising input on a masked message source makes no offer, but it is remembered. The next configuration write that gives the source a priority other than 0xFF produces exactly one offer.
- R4: A level source that becomes asserted while unmasked produces one offer and is then marked sent. While it stays sent, a resend produces no further offer.
- R5: Deasserting a level source clears its asserted state. After an EOI, a resend produces no offer for that source.
- R6: A reject naming a level source clears its sent state, so a following resend offers it again if it is still asserted and unmasked.
- R7: A reject naming a message source marks it rejected. The next resend offers it once and clears the mark, and a second resend offers nothing.
- R8: An EOI naming a message source changes nothing: a following resend produces no offer.
- R9: An EOI naming a level source clears its sent state, so a following resend offers it again while it stays asserted.
- R10: A configuration write to an asserted, unsent level source with a priority other than 0xFF produces an offer in the cycle after the write.
- R11: Pending offers are presented lowest local index first. An offer stays unchanged while offer_ready is low and is retired by one cycle with offer_valid and offer_ready both high.
- R12: Reset sets every priority and saved priority to 0xFF and clears all status and pending offers. Each source keeps its level or message type.
- R13: A reject or EOI whose number lies outside BASE to BASE+NUM_SRC-1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | NUM_SRC | Source lines: a level for level sources, rising edge for message sources |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index written |
| cfg_server | input | SRV_W | Target server number |
| cfg_prio | input | 8 | Priority, 0xFF masks |
| cfg_saved | input | 8 | Saved priority |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 1 reject, 2 EOI, 3 resend, 0 none |
| cmd_num | input | GNUM_W | Global source number for reject and EOI |
| offer_valid | output | 1 | An offer is presented |
| offer_ready | input | 1 | The presenter takes the offer |
| offer_server | output | SRV_W | Server of the offered source |
| offer_num | output | GNUM_W | Global number of the offered source |
| offer_prio | output | 8 | Priority of the offered source |

## Verification
The hardest case to reach is a source whose handshake state depends on a chain of earlier events. Examples are a level source that is asserted, sent, rejected and then resent, or a message pulse that was stored while masked and is replayed by a later configuration write. The bench builds each chain with directed command sequences on one source at a time, and it checks the offer channel after every step. Ordering is tested by pulsing two message sources in the same cycle and holding offer_ready low across several cycles.

// File: rtl/irq_src_pkg.sv
// Package: shared constants and command encoding for the interrupt source controller.
// Assumes priorities are 8 bits wide and that the all-ones value masks a source.
package irq_src_pkg;
    localparam int          PRIO_W      = 8;
    localparam logic [7:0]  PRIO_MASKED = 8'hFF;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_REJECT = 2'd1,
        OP_EOI    = 2'd2,
        OP_RESEND = 2'd3
    } cmd_op_e;
endpackage

// File: rtl/irq_src_entry.sv
// Module: state of one interrupt source: configuration, handshake bits and an offer request.
// Assumes the command decode upstream has already matched the global number to this entry.
// The grant clears the request before any event of the same cycle can set it again.
module irq_src_entry
    import irq_src_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic              cfg_hit,
    input  logic [SRV_W-1:0]  cfg_server,
    input  logic [PRIO_W-1:0] cfg_prio,
    input  logic [PRIO_W-1:0] cfg_saved,
    input  logic              rej_hit,
    input  logic              eoi_hit,
    input  logic              resend,
    input  logic              grant,
    output logic [SRV_W-1:0]  server,
    output logic [PRIO_W-1:0] prio,
    output logic              req
);
    logic [SRV_W-1:0]  server_q, server_n;
    logic [PRIO_W-1:0] prio_q, prio_n, saved_q, saved_n;
    logic asserted_q, asserted_n, sent_q, sent_n;
    logic rej_q, rej_n, mpend_q, mpend_n;
    logic line_q, req_q, req_n, trig;

    // Next-state rules for both source kinds; events are applied in a fixed order.
    always_comb begin
        server_n   = server_q;
        prio_n     = prio_q;
        saved_n    = saved_q;
        asserted_n = asserted_q;
        sent_n     = sent_q;
        rej_n      = rej_q;
        mpend_n    = mpend_q;
        req_n      = req_q;
        trig       = 1'b0;
        if (grant) begin
            req_n = 1'b0;
        end
        if (IS_LEVEL) begin
            asserted_n = line_in;
            if (rej_hit || eoi_hit) begin
                sent_n = 1'b0;
            end
            trig = (line_in != asserted_q) || cfg_hit || resend;
        end else begin
            if (line_in && !line_q) begin
                if (prio_q == PRIO_MASKED) mpend_n = 1'b1;
                else                       req_n   = 1'b1;
            end
            if (rej_hit) begin
                rej_n = 1'b1;
            end
        end
        if (cfg_hit) begin
            server_n = cfg_server;
            prio_n   = cfg_prio;
            saved_n  = cfg_saved;
        end
        if (IS_LEVEL) begin
            if (trig && prio_n != PRIO_MASKED && asserted_n && !sent_n) begin
                sent_n = 1'b1;
                req_n  = 1'b1;
            end
        end else begin
            if (cfg_hit && mpend_n && prio_n != PRIO_MASKED) begin
                mpend_n = 1'b0;
                req_n   = 1'b1;
            end
            if (resend && rej_n) begin
                rej_n = 1'b0;
                if (prio_n != PRIO_MASKED) req_n = 1'b1;
            end
        end
    end

    // State registers with synchronous reset to the masked, idle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            server_q   <= '0;
            prio_q     <= PRIO_MASKED;
            saved_q    <= PRIO_MASKED;
            asserted_q <= 1'b0;
            sent_q     <= 1'b0;
            rej_q      <= 1'b0;
            mpend_q    <= 1'b0;
            line_q     <= 1'b0;
            req_q      <= 1'b0;
        end else begin
            server_q   <= server_n;
            prio_q     <= prio_n;
            saved_q    <= saved_n;
            asserted_q <= asserted_n;
            sent_q     <= sent_n;
            rej_q      <= rej_n;
            mpend_q    <= mpend_n;
            line_q     <= line_in;
            req_q      <= req_n;
        end
    end

    assign server = server_q;
    assign prio   = prio_q;
    assign req    = req_q;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (prio_q == PRIO_MASKED && saved_q == PRIO_MASKED && !req_q
                    && !sent_q && !rej_q && !mpend_q && !asserted_q)); // R12
    AST_SENT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sent_q) |-> (asserted_q && prio_q != PRIO_MASKED)); // R4
    AST_PEND_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mpend_q) |-> (prio_q == PRIO_MASKED)); // R3
endmodule

// File: rtl/irq_offer_arb.sv
// Module: fixed-priority pick of the lowest requesting index and a one-hot grant on handshake.
// Assumes requests are already gated by the mask; the grant is valid only with ready high.
module irq_offer_arb #(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_vis,
    input  logic               ready,
    output logic               valid,
    output logic [IDX_W-1:0]   sel,
    output logic [NUM_SRC-1:0] grant
);
    // Scan downward so the lowest set index wins.
    always_comb begin
        sel = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_vis[i]) sel = IDX_W'(i);
        end
    end

    assign valid = |req_vis;

    // One grant bit, only for the selected entry and only on a completed handshake.
    always_comb begin
        grant = '0;
        if (valid && ready) grant[sel] = 1'b1;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R11
    AST_GRANT_HITS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & ~req_vis) == '0)); // R11
endmodule

// File: rtl/irq_src_ctrl.sv
// Module: top of the interrupt source controller: entries, command decode and offer channel.
// Assumes global numbers are local index plus BASE and that the source kind is fixed by LEVEL_MASK.
module irq_src_ctrl
    import irq_src_pkg::*;
#(
    parameter int NUM_SRC  = 8,
    parameter int SRV_W    = 4,
    parameter int GNUM_W   = 12,
    parameter int BASE     = 16,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = NUM_SRC'(15),
    localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [7:0]         cfg_prio,
    input  logic [7:0]         cfg_saved,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [GNUM_W-1:0]  cmd_num,
    output logic               offer_valid,
    input  logic               offer_ready,
    output logic [SRV_W-1:0]   offer_server,
    output logic [GNUM_W-1:0]  offer_num,
    output logic [7:0]         offer_prio
);
    localparam logic [GNUM_W-1:0] BASE_G = GNUM_W'(BASE);

    logic [SRV_W-1:0]  srv_arr  [NUM_SRC];
    logic [PRIO_W-1:0] prio_arr [NUM_SRC];
    logic [NUM_SRC-1:0] req, req_vis, grant;
    logic [GNUM_W-1:0] cmd_off;
    logic              cmd_in_rng, do_rej, do_eoi, do_resend;
    logic [IDX_W-1:0]  sel;

    // Translate the global number to a local index and qualify the command.
    always_comb begin
        cmd_off    = cmd_num - BASE_G;
        cmd_in_rng = (cmd_num >= BASE_G) && (cmd_off < GNUM_W'(NUM_SRC));
        do_rej     = cmd_valid && cmd_in_rng && (cmd_op == OP_REJECT);
        do_eoi     = cmd_valid && cmd_in_rng && (cmd_op == OP_EOI);
        do_resend  = cmd_valid && (cmd_op == OP_RESEND);
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic hit_idx;
        assign hit_idx = (cmd_off[IDX_W-1:0] == IDX_W'(g));

        irq_src_entry #(
            .SRV_W    (SRV_W),
            .IS_LEVEL (LEVEL_MASK[g])
        ) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .line_in    (src_in[g]),
            .cfg_hit    (cfg_we && cfg_idx == IDX_W'(g)),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .cfg_saved  (cfg_saved),
            .rej_hit    (do_rej && hit_idx),
            .eoi_hit    (do_eoi && hit_idx),
            .resend     (do_resend),
            .grant      (grant[g]),
            .server     (srv_arr[g]),
            .prio       (prio_arr[g]),
            .req        (req[g])
        );

        // A masked entry never competes for the offer channel.
        assign req_vis[g] = req[g] && (prio_arr[g] != PRIO_MASKED);
    end

    irq_offer_arb #(.NUM_SRC(NUM_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_vis (req_vis),
        .ready   (offer_ready),
        .valid   (offer_valid),
        .sel     (sel),
        .grant   (grant)
    );

    assign offer_server = srv_arr[sel];
    assign offer_prio   = prio_arr[sel];
    assign offer_num    = BASE_G + GNUM_W'(sel);

    AST_NO_MASKED_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_prio != PRIO_MASKED)); // R1
    AST_NUM_IN_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_num >= BASE_G && offer_num < BASE_G + GNUM_W'(NUM_SRC))); // R2
    AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (offer_valid && !offer_ready && !cfg_we && src_in == '0 && !cmd_valid)
            |=> (offer_valid && $stable(offer_num))); // R11
endmodule

// File: tb/irq_src_ctrl_tb.sv
`timescale 1ns/1ps
module irq_src_ctrl_tb;
    localparam int NSRC = 8;
    localparam int BNUM = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_in = '0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_idx = '0;
    logic [3:0] cfg_server = '0;
    logic [7:0] cfg_prio = '0, cfg_saved = '0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [11:0] cmd_num = '0;
    logic offer_valid, offer_ready = 1'b0;
    logic [3:0] offer_server;
    logic [11:0] offer_num;
    logic [7:0] offer_prio;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    irq_src_ctrl #(.NUM_SRC(NSRC), .SRV_W(4), .GNUM_W(12), .BASE(BNUM),
                   .LEVEL_MASK(8'h0F)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_num(cmd_num),
        .offer_valid(offer_valid), .offer_ready(offer_ready),
        .offer_server(offer_server), .offer_num(offer_num), .offer_prio(offer_prio)
    );

    typedef struct packed {
        logic [2:0] idx;
        logic [3:0] srv;
        logic [7:0] pri;
        logic       exp;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{3'd4, 4'd1,  8'h00, 1'b1},
        '{3'd5, 4'd9,  8'h80, 1'b1},
        '{3'd6, 4'd15, 8'hFE, 1'b1},
        '{3'd7, 4'd3,  8'h10, 1'b1},
        '{3'd7, 4'd3,  8'hFF, 1'b0}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare the offer channel with expectations; take the offer when one is expected.
    task automatic check_offer(input string tag, input logic ev, input logic [3:0] es,
                               input int en, input logic [7:0] ep);
        nchk++;
        if (offer_valid !== ev ||
            (ev && (offer_server !== es || offer_num !== 12'(en) || offer_prio !== ep))) begin
            nerr++;
            $display("FAIL %s: got v=%0b srv=%0d num=%0d pri=%0h, expected v=%0b srv=%0d num=%0d pri=%0h",
                     tag, offer_valid, offer_server, offer_num, offer_prio, ev, es, en, ep);
        end
        if (ev && offer_valid) begin
            offer_ready = 1'b1;
            tick();
            offer_ready = 1'b0;
        end
    endtask

    task automatic cfg_write(input int idx, input logic [3:0] s, input logic [7:0] p);
        cfg_idx = 3'(idx); cfg_server = s; cfg_prio = p; cfg_saved = ~p; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse(input int idx);
        src_in[idx] = 1'b1;
        tick();
        src_in[idx] = 1'b0;
    endtask

    task automatic command(input logic [1:0] op, input int num);
        cmd_op = op; cmd_num = 12'(num); cmd_valid = 1'b1;
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();
        check_offer("R12 idle after reset", 1'b0, 0, 0, 0);

        // Message pulse vectors (R2; last row masked, R1).
        for (int k = 0; k < 5; k++) begin
            cfg_write(VEC[k].idx, VEC[k].srv, VEC[k].pri);
            pulse(VEC[k].idx);
            check_offer("R2 message vector", VEC[k].exp, VEC[k].srv,
                        BNUM + VEC[k].idx, VEC[k].pri);
            tick();
        end

        // R12: reset masks all; a pulse on source 4 is held as pending (R3).
        do_reset();
        pulse(4);
        check_offer("R12 pulse after reset masked", 1'b0, 0, 0, 0);
        cfg_write(4, 4'd2, 8'h05);
        check_offer("R3 pending replay on unmask", 1'b1, 4'd2, BNUM + 4, 8'h05);
        tick();
        check_offer("R3 replay only once", 1'b0, 0, 0, 0);

        // R4 and R12 type kept: source 0 is still level.
        cfg_write(0, 4'd6, 8'h03);
        src_in[0] = 1'b1;
        tick();
        check_offer("R4 level assert offers", 1'b1, 4'd6, BNUM, 8'h03);
        tick();
        check_offer("R4 no repeat while sent", 1'b0, 0, 0, 0);
        command(2'd3, 0);
        check_offer("R4 resend while sent", 1'b0, 0, 0, 0);

        command(2'd1, BNUM);
        check_offer("R6 reject alone no offer", 1'b0, 0, 0, 0);
        command(2'd3, 0);
        check_offer("R6 resend after reject", 1'b1, 4'd6, BNUM, 8'h03);

        command(2'd2, BNUM);
        command(2'd3, 0);
        check_offer("R9 resend after EOI", 1'b1, 4'd6, BNUM, 8'h03);

        src_in[0] = 1'b0;
        tick();
        command(2'd2, BNUM);
        command(2'd3, 0);
        check_offer("R5 deasserted no offer", 1'b0, 0, 0, 0);

        // R1 and R10: level source 1 asserted while masked, then unmasked.
        src_in[1] = 1'b1;
        tick();
        check_offer("R1 masked level silent", 1'b0, 0, 0, 0);
        cfg_write(1, 4'd11, 8'h07);
        check_offer("R10 config write offers", 1'b1, 4'd11, BNUM + 1, 8'h07);

        // R7 and R8 on message source 5.
        cfg_write(5, 4'd8, 8'h04);
        pulse(5);
        check_offer("R7 first delivery", 1'b1, 4'd8, BNUM + 5, 8'h04);
        command(2'd1, BNUM + 5);
        check_offer("R7 reject alone no offer", 1'b0, 0, 0, 0);
        command(2'd3, 0);
        check_offer("R7 resend replays", 1'b1, 4'd8, BNUM + 5, 8'h04);
        command(2'd3, 0);
        check_offer("R7 second resend silent", 1'b0, 0, 0, 0);
        command(2'd2, BNUM + 5);
        command(2'd3, 0);
        check_offer("R8 message EOI no effect", 1'b0, 0, 0, 0);

        // R13: out-of-range numbers ignored; source 1 stays sent.
        command(2'd1, BNUM + NSRC + 1);
        command(2'd2, BNUM - 15);
        command(2'd3, 0);
        check_offer("R13 out of range ignored", 1'b0, 0, 0, 0);

        // R11: simultaneous pulses on 6 and 4, ascending order, held while stalled.
        cfg_write(6, 4'd12, 8'h02);
        src_in[6] = 1'b1; src_in[4] = 1'b1;
        tick();
        src_in = '0;
        tick(); tick();
        nchk++;
        if (!(offer_valid && offer_num == 12'(BNUM + 4))) begin
            nerr++;
            $display("FAIL R11 held offer: got v=%0b num=%0d, expected v=1 num=%0d",
                     offer_valid, offer_num, BNUM + 4);
        end
        check_offer("R11 lower index first", 1'b1, 4'd2, BNUM + 4, 8'h05);
        check_offer("R11 next index second", 1'b1, 4'd12, BNUM + 6, 8'h02);
        check_offer("R11 queue drained", 1'b0, 0, 0, 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule